// File: doc/BRIEF.md
# Keyboard Status and Data Port

This block sits on a processor's memory read bus and claims two fixed addresses. One address reports whether a keystroke is waiting and the other hands out the waiting keystroke. Key codes arrive from a keyboard front end as a one-cycle valid strobe with an 8-bit code. They are queued in a small first-in first-out store, so the processor can fetch them later in arrival order.

A status read only reports occupancy and changes nothing. A data read returns the oldest key and removes it. If no key is waiting, the data read is not answered with stale data. The block holds bus ready low until a key arrives, then completes the read with that key.

Every other address is forwarded unchanged to the backing memory, which answers in the same cycle. Each cycle in which `bus_rd` and `bus_ready` are both high is one completed read. A requester that sees ready low keeps its address and read strobe steady.

Top module: `kbd_port`

## Requirements
- R1: A read of address 0xFE00 completes in the same cycle (ready high). It returns 0x8000 (only bit 15 set) when at least one key is queued, and 0x0000 when none is queued.
- R2: A read of address 0xFE02 with a key queued completes in the same cycle. It returns the oldest queued key in bits 7:0, with bits 15:8 zero, so keys come out in arrival order.
- R3: Each completed read of 0xFE02 removes exactly one key. A later read of 0xFE00 returns 0x0000 once every queued key has been read.
- R4: A read of 0xFE02 while the queue is empty keeps `bus_ready` low. This includes the cycle in which a key is strobed in. The read completes in the next cycle, returning that key.
- R5: A read of any address other than 0xFE00 and 0xFE02 raises `mem_rd`, drives `mem_addr` with the bus address, returns `mem_rdata` on `bus_rdata` and completes in the same cycle. Reads of the two keyboard addresses keep `mem_rd` low.
- R6: A read of 0xFE00 never removes a key. The key read next from 0xFE02 is the same one that would have been returned without the status read.
- R7: The queue holds 8 keys. A key strobed while 8 are queued, with no removal in that cycle, is discarded. That event sets `kbd_overflow`, which stays set until reset.
- R8: After reset the queue is empty and `kbd_overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe: a new key code is present |
| key_code | input | 8 | Key code accompanying the strobe |
| bus_rd | input | 1 | Read request from the processor |
| bus_addr | input | 16 | Read address |
| bus_rdata | output | 16 | Read data returned to the processor |
| bus_ready | output | 1 | Read completes in this cycle when high |
| mem_rd | output | 1 | Read request forwarded to backing memory |
| mem_addr | output | 16 | Address forwarded to backing memory |
| mem_rdata | input | 16 | Data from backing memory, same cycle |
| kbd_overflow | output | 1 | Sticky flag: a key was discarded on a full queue |

## Verification
The bench builds the block with its default values: depth 8, which selects the power-of-two pointer-wrap variant, and the two addresses 0xFE00 and 0xFE02. With that depth, a burst of nine keys reaches the full queue, the discarded ninth key and the overflow flag. Draining the queue afterwards drives both pointers through their wrap. Depth 8 also keeps the stalled-read case short enough to watch ready cycle by cycle. The rarely used word at 0xFE01, which lies between the two claimed addresses, is checked to go to memory.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
   typedef enum logic [1:0] {
      SEL_MEM  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2
   } kbd_sel_e;
endpackage

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
   parameter int KEY_W = 8,
   parameter int DEPTH = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [KEY_W-1:0]               push_data,
   input  logic                           pop,
   output logic [KEY_W-1:0]               head,
   output logic                           empty,
   output logic                           full,
   output logic [$clog2(DEPTH+1)-1:0]     level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("kbd_fifo: DEPTH must be at least 2");
   end

   logic [KEY_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             do_push;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign level   = cnt;
   assign head    = slot[rd_ptr];
   assign do_push = push && (!full || pop);

   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[i] <= '0;
         else if (do_push && wr_ptr == PTR_W'(i))
            slot[i] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (pop)     rd_ptr <= rd_nxt;
         case ({do_push, pop})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/kbd_decode.sv
module kbd_decode
   import kbd_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
   input  logic [ADDR_W-1:0] addr,
   output kbd_sel_e          sel
);
   always_comb begin
      if (addr == STATUS_ADDR)    sel = SEL_STAT;
      else if (addr == DATA_ADDR) sel = SEL_DATA;
      else                        sel = SEL_MEM;
   end
endmodule

// File: rtl/kbd_rsp.sv
module kbd_rsp
   import kbd_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int KEY_W      = 8,
   parameter int STATUS_BIT = 15
) (
   input  kbd_sel_e          sel,
   input  logic              rd,
   input  logic              empty,
   input  logic [KEY_W-1:0]  head,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready,
   output logic              mem_rd,
   output logic              pop
);
   logic [DATA_W-1:0] stat_word;

   assign stat_word = empty ? '0 : (DATA_W'(1) << STATUS_BIT);
   assign mem_rd    = rd && (sel == SEL_MEM);
   assign pop       = rd && (sel == SEL_DATA) && !empty;
   assign ready     = (sel == SEL_DATA) ? !empty : 1'b1;

   always_comb begin
      case (sel)
         SEL_STAT: rdata = stat_word;
         SEL_DATA: rdata = empty ? '0 : DATA_W'(head);
         default:  rdata = mem_rdata;
      endcase
   end
endmodule

// File: rtl/kbd_port.sv
module kbd_port
   import kbd_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 16,
   parameter int                KEY_W       = 8,
   parameter int                DEPTH       = 8,
   parameter int                STATUS_BIT  = 15,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [KEY_W-1:0]  key_code,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              kbd_overflow
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (KEY_W >= DATA_W) begin : g_bad_key_w
      $error("kbd_port: KEY_W must be narrower than DATA_W");
   end
   if (STATUS_BIT >= DATA_W) begin : g_bad_stat_bit
      $error("kbd_port: STATUS_BIT outside data word");
   end
   if (STATUS_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("kbd_port: status and data addresses must differ");
   end

   kbd_sel_e         sel;
   logic             fifo_pop, fifo_empty, fifo_full;
   logic [KEY_W-1:0] fifo_head;
   logic [CNT_W-1:0] fifo_level;
   logic             ovf_q;

   kbd_decode #(
      .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_dec (
      .addr(bus_addr), .sel(sel)
   );

   kbd_fifo #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(key_valid), .push_data(key_code), .pop(fifo_pop),
      .head(fifo_head), .empty(fifo_empty), .full(fifo_full),
      .level(fifo_level)
   );

   kbd_rsp #(.DATA_W(DATA_W), .KEY_W(KEY_W), .STATUS_BIT(STATUS_BIT)) u_rsp (
      .sel(sel), .rd(bus_rd), .empty(fifo_empty), .head(fifo_head),
      .mem_rdata(mem_rdata), .rdata(bus_rdata), .ready(bus_ready),
      .mem_rd(mem_rd), .pop(fifo_pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (key_valid && fifo_full && !fifo_pop)
         ovf_q <= 1'b1;
   end

   assign mem_addr     = bus_addr;
   assign kbd_overflow = ovf_q;
endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk #(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 16,
   parameter int                KEY_W       = 8,
   parameter int                DEPTH       = 8,
   parameter int                STATUS_BIT  = 15,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       key_valid,
   input logic                       bus_rd,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic                       bus_ready,
   input logic                       mem_rd,
   input logic [DATA_W-1:0]          mem_rdata,
   input logic                       kbd_overflow,
   input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic st_rd, dt_rd, mm_rd;
   assign st_rd = bus_rd && bus_addr == STATUS_ADDR;
   assign dt_rd = bus_rd && bus_addr == DATA_ADDR;
   assign mm_rd = bus_rd && !(bus_addr == STATUS_ADDR) && !(bus_addr == DATA_ADDR);

   p_status_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd |-> bus_ready &&
         bus_rdata == ((fifo_level != '0) ? (DATA_W'(1) << STATUS_BIT) : '0));

   p_data_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_rd && bus_ready) |-> bus_rdata[DATA_W-1:KEY_W] == '0);

   p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_rd && bus_ready && !key_valid) |=> fifo_level == $past(fifo_level) - CNT_W'(1));

   p_stall_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_rd && fifo_level == '0) |-> !bus_ready);

   p_mem_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mm_rd |-> mem_rd && bus_ready && bus_rdata == mem_rdata);

   p_kbd_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd || dt_rd) |-> !mem_rd);

   p_status_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd |=> fifo_level >= $past(fifo_level));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_overflow |=> kbd_overflow);

   p_level_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= CNT_W'(DEPTH));
endmodule

bind kbd_port kbd_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .DEPTH(DEPTH),
   .STATUS_BIT(STATUS_BIT), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
   .mem_rd(mem_rd), .mem_rdata(mem_rdata), .kbd_overflow(kbd_overflow),
   .fifo_level(fifo_level)
);

// File: tb/kbd_port_tb_top.sv
`timescale 1ns/1ps
module kbd_port_tb_top;
   localparam logic [15:0] A_STAT = 16'hFE00;
   localparam logic [15:0] A_DATA = 16'hFE02;
   localparam int          QCAP   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_valid = 1'b0;
   logic [7:0]  key_code = '0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_rdata;
   logic        bus_ready;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata;
   logic        kbd_overflow;

   int   total = 0;
   int   bad = 0;
   bit   finished = 0;
   logic [7:0] exp_q [$];

   always #2.5 clk = ~clk;

   assign mem_rdata = mem_rd ? (mem_addr ^ 16'h5A3C) : 16'hDEAD;

   kbd_port dut_i (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .kbd_overflow(kbd_overflow)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: every completed data read pops the scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_rd && bus_ready && bus_addr == A_DATA) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected key", bus_rdata, 16'h0000);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(bus_rdata == {8'h00, e}, "R2/R3 key order", bus_rdata, {8'h00, e});
         end
      end
   end

   task automatic send_key(input logic [7:0] k);
      key_code  = k;
      key_valid = 1'b1;
      if (exp_q.size() < QCAP) exp_q.push_back(k);
      @(posedge clk); #1;
      key_valid = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [15:0] d,
                           output logic m);
      bus_addr = a;
      bus_rd   = 1'b1;
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         if (bus_ready) break;
      end
      d = bus_rdata;
      m = mem_rd;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic status_is(input logic [15:0] exp, input string tag);
      logic [15:0] d;
      logic m;
      bus_read(A_STAT, d, m);
      check(d == exp, tag, d, exp);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic m;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(kbd_overflow == 1'b0, "R8 overflow after reset", 16'(kbd_overflow), 16'h0);
      status_is(16'h0000, "R8 empty after reset");

      // main ordering
      send_key(8'h41); send_key(8'h42); send_key(8'h43);
      status_is(16'h8000, "R1 status with keys");
      for (int i = 0; i < 3; i++) bus_read(A_DATA, d, m);
      status_is(16'h0000, "R3 status after drain");
      check(exp_q.size() == 0, "R3 scoreboard drained", 16'(exp_q.size()), 16'h0);

      // status read side effects
      send_key(8'h7E);
      status_is(16'h8000, "R6 first status");
      status_is(16'h8000, "R6 second status");
      bus_read(A_DATA, d, m);
      check(d == 16'h007E, "R6 key survives status reads", d, 16'h007E);
      check(m == 1'b0, "R5 no memory read on data addr", 16'(m), 16'h0);

      // memory pass-through
      bus_read(16'h1234, d, m);
      check(d == (16'h1234 ^ 16'h5A3C) && m, "R5 memory 0x1234", d, 16'h1234 ^ 16'h5A3C);
      bus_read(16'hFE01, d, m);
      check(d == (16'hFE01 ^ 16'h5A3C) && m, "R5 memory 0xFE01", d, 16'hFE01 ^ 16'h5A3C);
      bus_read(16'hFFFF, d, m);
      check(d == (16'hFFFF ^ 16'h5A3C) && m, "R5 memory 0xFFFF", d, 16'hFFFF ^ 16'h5A3C);

      // stall on empty
      bus_addr = A_DATA;
      bus_rd   = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(!bus_ready, "R4 ready low while empty", 16'(bus_ready), 16'h0);
      end
      @(posedge clk); #1;
      key_code  = 8'hC5;
      key_valid = 1'b1;
      exp_q.push_back(8'hC5);
      @(negedge clk);
      check(!bus_ready, "R4 ready low in strobe cycle", 16'(bus_ready), 16'h0);
      @(posedge clk); #1;
      key_valid = 1'b0;
      @(negedge clk);
      check(bus_ready && bus_rdata == 16'h00C5, "R4 stalled read completes", bus_rdata, 16'h00C5);
      @(posedge clk); #1;
      bus_rd = 1'b0;

      // overflow
      check(kbd_overflow == 1'b0, "R7 no overflow yet", 16'(kbd_overflow), 16'h0);
      for (int i = 0; i < 9; i++) send_key(8'h10 + 8'(i));
      @(negedge clk);
      check(kbd_overflow == 1'b1, "R7 overflow set", 16'(kbd_overflow), 16'h1);
      for (int i = 0; i < 8; i++) bus_read(A_DATA, d, m);
      status_is(16'h0000, "R7 ninth key dropped");
      check(kbd_overflow == 1'b1, "R7 overflow sticky", 16'(kbd_overflow), 16'h1);

      // wrapped pointers still ordered
      send_key(8'hA1); send_key(8'hA2);
      bus_read(A_DATA, d, m);
      bus_read(A_DATA, d, m);
      check(d == 16'h00A2, "R2 order after wrap", d, 16'h00A2);
      check(exp_q.size() == 0, "R3 all keys consumed", 16'(exp_q.size()), 16'h0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule